// File: doc/BRIEF.md
# Two-Wire Alarm Bus Master with Address Scan

This block is the controlling end of a two-wire alarm loop on which up to thirty addressed sensor nodes share one pair of conductors for power and data. It turns each transaction into a string of bit slots. Every slot begins with a one-cycle timing strobe, and while the master drives the line a data level is held for the whole slot. An analog line driver outside the block converts the strobe, data and drive-enable signals into line voltages. A receive comparator returns the level that a node pulls onto the line while the master has let go of it.

Two kinds of work reach the line. A single read or write can be queued through a one-deep request port. When nothing is queued and scanning is enabled, the block polls the node addresses one after another. It keeps the last two status bits from every node in a register array, together with a response-parity error flag and a silent-node flag for each address. Each finished frame is also reported on a one-cycle completion strobe. A write that is sent with deliberately inverted data parity, which tests how a node blocks bad writes, marks the node as holding a fault. The next write to that node is then preceded automatically by a read that clears the fault.

Top module: `alarm_bus_master`

## Requirements
- R1: After reset, line_drive is 1 and line_strobe and line_data are 0. req_ready is 1, and every bit of node_status, node_perr and node_noresp is 0.
- R2: A frame starts with the address, most significant bit first, in slots 0 to 4. Slot 5 carries the even address parity, which is the XOR of the five address bits. Slot 6 carries the command: 1 means read and 0 means write.
- R3: A write frame has 10 slots. Slot 7 carries req_data[0], slot 8 carries req_data[1], and slot 9 carries req_data[0] XOR req_data[1], inverted when req_par_inv was set. line_drive stays 1 for the whole frame.
- R4: A read frame has 11 slots. line_drive is 0 in slots 7 to 10, and line_data is 0 whenever line_drive is 0. line_rx is sampled at the end of each of these slots as follows: slot 7 is a presence marker that must be 1, slot 8 is status bit 0, slot 9 is status bit 1 and slot 10 is the node's parity. node_status[2a+1:2a] takes {bit1, bit0}. node_perr[a] is set when the three bits from slots 8 to 10 have odd parity and is cleared otherwise.
- R5: When the presence marker samples as 0, node_noresp[a] is set, node_perr[a] is cleared and node_status for that address keeps its previous value. A read answered by a node clears node_noresp[a]. done_perr and done_noresp are never both 1.
- R6: Each slot lasts bit_div+1 clock cycles and has exactly one single-cycle strobe, in its first cycle. Between frames sent back to back, the spacing from the last strobe of one frame to the first strobe of the next is (bit_div+1)*(GAP_SLOTS+1)+1 cycles, and no strobe occurs in between.
- R7: With scan_en set and no request queued, the block issues reads to addresses 0, 1, 2 and onward in turn. After N_NODES-1 (29 by default) it returns to 0.
- R8: A request is taken on a cycle where both req_valid and req_ready are 1, after which req_ready stays 0 until the request is launched. A queued request is launched before the next scan read, and scanning then resumes at the address it would have polled next.
- R9: A write sent with req_par_inv marks its address as faulted. The next write to a faulted address is preceded by an automatically inserted read of that address. Any completed read to the address clears the mark.
- R10: Each frame ends with a single-cycle done_valid that carries the address, the command (done_write is 1 for a write), the received status and the two error flags. For writes the status and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_div | input | DIV_W | Slot length minus one, in clock cycles |
| scan_en | input | 1 | Enables automatic polling of all addresses |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request slot is empty |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Node address |
| req_data | input | 2 | Output bits for a write |
| req_par_inv | input | 1 | Send a write with inverted data parity |
| line_strobe | output | 1 | One-cycle timing strobe at the start of each slot |
| line_data | output | 1 | Data level for the current slot |
| line_drive | output | 1 | 1 while the master drives the line, 0 during the response window |
| line_rx | input | 1 | Level returned by the line receiver |
| done_valid | output | 1 | One-cycle frame completion |
| done_write | output | 1 | Completed frame was a write |
| done_addr | output | ADDR_W | Address of the completed frame |
| done_status | output | 2 | Received status {bit1, bit0} |
| done_perr | output | 1 | Response parity error |
| done_noresp | output | 1 | No presence marker |
| node_status | output | 2*N_NODES | Stored status, two bits per address |
| node_perr | output | N_NODES | Per-address response parity error |
| node_noresp | output | N_NODES | Per-address silent-node flag |

## Verification
The bench keeps N_NODES at 30, so one full poll actually passes the return from 29 to 0. It sets DIV_W to 4 and GAP_SLOTS to 2, and it samples at the end of each slot. It drives bit_div as 2 for most frames, where spacing inside a slot is visible. It also drives bit_div as 0, the limit case in which every slot is one cycle long and strobes arrive on consecutive cycles. A behavioural node model on the line decodes every frame, answers reads from per-address settings (present, silent or bad parity), and logs frames. This lets the bench check the inserted fault-clearing read and the position of a queued write inside a running scan.

// File: rtl/abm_pkg.sv
`timescale 1ns/1ps
package abm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TX   = 2'd1,
      ST_RX   = 2'd2,
      ST_GAP  = 2'd3
   } abm_state_e;

   // Number of response slots: presence marker, two status bits, parity.
   localparam int RESP_SLOTS = 4;
endpackage

// File: rtl/abm_bit_timer.sv
`timescale 1ns/1ps
module abm_bit_timer #(
   parameter int DIV_W         = 8,
   parameter bit SAMPLE_AT_END = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             slot_start,
   output logic             slot_end,
   output logic             sample
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || cnt == div)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign slot_start = run && (cnt == '0);
   assign slot_end   = run && (cnt == div);

   generate
      if (SAMPLE_AT_END) begin : g_smp_end
         assign sample = slot_end;
      end else begin : g_smp_mid
         assign sample = run && (cnt == (div >> 1));
      end
   endgenerate
endmodule

// File: rtl/abm_frame_seq.sv
`timescale 1ns/1ps
module abm_frame_seq
   import abm_pkg::*;
#(
   parameter int ADDR_W        = 5,
   parameter int DIV_W         = 8,
   parameter int GAP_SLOTS     = 2,
   parameter bit SAMPLE_AT_END = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  bit_div,
   input  logic              go,
   input  logic              go_write,
   input  logic [ADDR_W-1:0] go_addr,
   input  logic [1:0]        go_data,
   input  logic              go_par_inv,
   input  logic              line_rx,
   output logic              ready,
   output logic              line_strobe,
   output logic              line_data,
   output logic              line_drive,
   output logic              done_valid,
   output logic              done_write,
   output logic [ADDR_W-1:0] done_addr,
   output logic [1:0]        done_status,
   output logic              done_perr,
   output logic              done_noresp,
   output logic              done_bad_wpar
);
   localparam int TXW    = ADDR_W + 5;
   localparam int RD_LEN = ADDR_W + 2;
   localparam int WR_LEN = ADDR_W + 5;
   localparam int SPAN   = (GAP_SLOTS > WR_LEN) ? GAP_SLOTS : WR_LEN;
   localparam int SLOT_W = $clog2(SPAN + 1);

   abm_state_e              state;
   logic [SLOT_W-1:0]       slot;
   logic [TXW-1:0]          sh;
   logic [RESP_SLOTS-1:0]   rxsh;
   logic                    cur_write;
   logic                    cur_inv;
   logic [ADDR_W-1:0]       cur_addr;
   logic                    fin;
   logic                    slot_start, slot_end, sample;
   logic [SLOT_W-1:0]       tx_last;

   abm_bit_timer #(
      .DIV_W         (DIV_W),
      .SAMPLE_AT_END (SAMPLE_AT_END)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (state != ST_IDLE),
      .div        (bit_div),
      .slot_start (slot_start),
      .slot_end   (slot_end),
      .sample     (sample)
   );

   assign tx_last = cur_write ? SLOT_W'(WR_LEN - 1) : SLOT_W'(RD_LEN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         slot          <= '0;
         sh            <= '0;
         rxsh          <= '0;
         cur_write     <= 1'b0;
         cur_inv       <= 1'b0;
         cur_addr      <= '0;
         fin           <= 1'b0;
         done_valid    <= 1'b0;
         done_write    <= 1'b0;
         done_addr     <= '0;
         done_status   <= '0;
         done_perr     <= 1'b0;
         done_noresp   <= 1'b0;
         done_bad_wpar <= 1'b0;
      end else begin
         fin        <= 1'b0;
         done_valid <= 1'b0;
         if (fin) begin
            done_valid    <= 1'b1;
            done_write    <= cur_write;
            done_addr     <= cur_addr;
            done_bad_wpar <= cur_write && cur_inv;
            if (cur_write) begin
               done_status <= '0;
               done_perr   <= 1'b0;
               done_noresp <= 1'b0;
            end else begin
               done_status <= {rxsh[1], rxsh[2]};
               done_noresp <= !rxsh[3];
               done_perr   <= rxsh[3] && (rxsh[2] ^ rxsh[1] ^ rxsh[0]);
            end
         end
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  sh        <= {go_addr, ^go_addr, ~go_write, go_data[0], go_data[1],
                                (go_data[0] ^ go_data[1]) ^ go_par_inv};
                  cur_write <= go_write;
                  cur_inv   <= go_par_inv;
                  cur_addr  <= go_addr;
                  slot      <= '0;
                  state     <= ST_TX;
               end
            end
            ST_TX: begin
               if (slot_end) begin
                  sh <= sh << 1;
                  if (slot == tx_last) begin
                     slot <= '0;
                     if (cur_write) begin
                        state <= ST_GAP;
                        fin   <= 1'b1;
                     end else begin
                        state <= ST_RX;
                     end
                  end else begin
                     slot <= slot + 1'b1;
                  end
               end
            end
            ST_RX: begin
               if (sample)
                  rxsh <= {rxsh[RESP_SLOTS-2:0], line_rx};
               if (slot_end) begin
                  if (slot == SLOT_W'(RESP_SLOTS - 1)) begin
                     slot  <= '0;
                     state <= ST_GAP;
                     fin   <= 1'b1;
                  end else begin
                     slot <= slot + 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (slot_end) begin
                  if (slot == SLOT_W'(GAP_SLOTS - 1)) begin
                     slot  <= '0;
                     state <= ST_IDLE;
                  end else begin
                     slot <= slot + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ready       = (state == ST_IDLE);
   assign line_strobe = slot_start && (state == ST_TX || state == ST_RX);
   assign line_data   = (state == ST_TX) && sh[TXW-1];
   assign line_drive  = (state != ST_RX);
endmodule

// File: rtl/abm_result_store.sv
`timescale 1ns/1ps
module abm_result_store #(
   parameter int N_NODES = 30,
   parameter int ADDR_W  = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd,
   input  logic                 upd_write,
   input  logic [ADDR_W-1:0]    upd_addr,
   input  logic [1:0]           upd_status,
   input  logic                 upd_perr,
   input  logic                 upd_noresp,
   input  logic                 upd_bad_wpar,
   output logic [2*N_NODES-1:0] status_flat,
   output logic [N_NODES-1:0]   perr_flat,
   output logic [N_NODES-1:0]   noresp_flat,
   output logic [N_NODES-1:0]   pend_flat
);
   generate
      for (genvar i = 0; i < N_NODES; i++) begin : g_node
         logic hit;
         assign hit = upd && (upd_addr == ADDR_W'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               status_flat[2*i +: 2] <= '0;
               perr_flat[i]          <= 1'b0;
               noresp_flat[i]        <= 1'b0;
               pend_flat[i]          <= 1'b0;
            end else if (hit) begin
               if (upd_write) begin
                  if (upd_bad_wpar)
                     pend_flat[i] <= 1'b1;
               end else begin
                  pend_flat[i]   <= 1'b0;
                  noresp_flat[i] <= upd_noresp;
                  perr_flat[i]   <= upd_perr;
                  if (!upd_noresp)
                     status_flat[2*i +: 2] <= upd_status;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/alarm_bus_master.sv
`timescale 1ns/1ps
module alarm_bus_master #(
   parameter int N_NODES       = 30,
   parameter int DIV_W         = 8,
   parameter int GAP_SLOTS     = 2,
   parameter bit SAMPLE_AT_END = 1'b1,
   localparam int ADDR_W       = $clog2(N_NODES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DIV_W-1:0]     bit_div,
   input  logic                 scan_en,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [1:0]           req_data,
   input  logic                 req_par_inv,
   output logic                 line_strobe,
   output logic                 line_data,
   output logic                 line_drive,
   input  logic                 line_rx,
   output logic                 done_valid,
   output logic                 done_write,
   output logic [ADDR_W-1:0]    done_addr,
   output logic [1:0]           done_status,
   output logic                 done_perr,
   output logic                 done_noresp,
   output logic [2*N_NODES-1:0] node_status,
   output logic [N_NODES-1:0]   node_perr,
   output logic [N_NODES-1:0]   node_noresp
);
   localparam int SPAN_N = 1 << ADDR_W;

   generate
      if (N_NODES < 2)   begin : g_bad_n   $error("N_NODES must be at least 2");   end
      if (GAP_SLOTS < 1) begin : g_bad_gap $error("GAP_SLOTS must be at least 1"); end
      if (DIV_W < 1)     begin : g_bad_div $error("DIV_W must be at least 1");     end
   endgenerate

   logic                h_valid, h_write, h_inv;
   logic [ADDR_W-1:0]   h_addr;
   logic [1:0]          h_data;
   logic [ADDR_W-1:0]   scan_ptr;
   logic [N_NODES-1:0]  pend_flat;
   logic [SPAN_N-1:0]   pend_ext;
   logic                need_clear;
   logic                seq_ready, done_bad_wpar;
   logic                go, go_write, go_inv;
   logic [ADDR_W-1:0]   go_addr;
   logic [1:0]          go_data;

   always_comb begin
      pend_ext              = '0;
      pend_ext[N_NODES-1:0] = pend_flat;
   end

   assign need_clear = h_write && pend_ext[h_addr];
   assign req_ready  = !h_valid;

   // Queued request first, inserted fault-clearing read before a write, then scan.
   always_comb begin
      go       = 1'b0;
      go_write = 1'b0;
      go_inv   = 1'b0;
      go_addr  = scan_ptr;
      go_data  = h_data;
      if (seq_ready) begin
         if (h_valid) begin
            go      = 1'b1;
            go_addr = h_addr;
            if (!need_clear) begin
               go_write = h_write;
               go_inv   = h_inv;
            end
         end else if (scan_en) begin
            go = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_valid  <= 1'b0;
         h_write  <= 1'b0;
         h_inv    <= 1'b0;
         h_addr   <= '0;
         h_data   <= '0;
         scan_ptr <= '0;
      end else begin
         if (req_valid && req_ready) begin
            h_valid <= 1'b1;
            h_write <= req_write;
            h_inv   <= req_par_inv;
            h_addr  <= req_addr;
            h_data  <= req_data;
         end else if (go && h_valid && !need_clear) begin
            h_valid <= 1'b0;
         end
         if (go && !h_valid)
            scan_ptr <= (scan_ptr == ADDR_W'(N_NODES - 1)) ? '0 : scan_ptr + 1'b1;
      end
   end

   abm_frame_seq #(
      .ADDR_W        (ADDR_W),
      .DIV_W         (DIV_W),
      .GAP_SLOTS     (GAP_SLOTS),
      .SAMPLE_AT_END (SAMPLE_AT_END)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .bit_div       (bit_div),
      .go            (go),
      .go_write      (go_write),
      .go_addr       (go_addr),
      .go_data       (go_data),
      .go_par_inv    (go_inv),
      .line_rx       (line_rx),
      .ready         (seq_ready),
      .line_strobe   (line_strobe),
      .line_data     (line_data),
      .line_drive    (line_drive),
      .done_valid    (done_valid),
      .done_write    (done_write),
      .done_addr     (done_addr),
      .done_status   (done_status),
      .done_perr     (done_perr),
      .done_noresp   (done_noresp),
      .done_bad_wpar (done_bad_wpar)
   );

   abm_result_store #(
      .N_NODES (N_NODES),
      .ADDR_W  (ADDR_W)
   ) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .upd          (done_valid),
      .upd_write    (done_write),
      .upd_addr     (done_addr),
      .upd_status   (done_status),
      .upd_perr     (done_perr),
      .upd_noresp   (done_noresp),
      .upd_bad_wpar (done_bad_wpar),
      .status_flat  (node_status),
      .perr_flat    (node_perr),
      .noresp_flat  (node_noresp),
      .pend_flat    (pend_flat)
   );
endmodule

// File: rtl/alarm_bus_master_chk.sv
`timescale 1ns/1ps
module alarm_bus_master_chk #(
   parameter int N_NODES = 30,
   parameter int DIV_W   = 8,
   parameter int ADDR_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DIV_W-1:0]  bit_div,
   input logic              line_strobe,
   input logic              line_data,
   input logic              line_drive,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done_valid,
   input logic              done_perr,
   input logic              done_noresp,
   input logic [ADDR_W-1:0] scan_ptr
);
   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_strobe && bit_div != '0) |=> !line_strobe);

   assert_release_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !line_drive |-> !line_data);

   assert_scan_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      scan_ptr <= ADDR_W'(N_NODES - 1));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_accept_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_flag_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_noresp) |-> !done_perr);
endmodule

bind alarm_bus_master alarm_bus_master_chk #(
   .N_NODES (N_NODES),
   .DIV_W   (DIV_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_div     (bit_div),
   .line_strobe (line_strobe),
   .line_data   (line_data),
   .line_drive  (line_drive),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .done_valid  (done_valid),
   .done_perr   (done_perr),
   .done_noresp (done_noresp),
   .scan_ptr    (scan_ptr)
);

// File: tb/sim_alarm_bus_master.sv
`timescale 1ns/1ps
module sim_alarm_bus_master;
   localparam int N   = 30;
   localparam int DW  = 4;
   localparam int GAP = 2;
   localparam int AW  = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] bit_div = 4'd2;
   logic          scan_en = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_par_inv = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_data = '0;
   logic          line_strobe, line_data, line_drive;
   logic          line_rx = 1'b0;
   logic          done_valid, done_write, done_perr, done_noresp;
   logic [AW-1:0] done_addr;
   logic [1:0]    done_status;
   logic [2*N-1:0] node_status;
   logic [N-1:0]  node_perr, node_noresp;

   always #5 clk = ~clk;

   alarm_bus_master #(.N_NODES(N), .DIV_W(DW), .GAP_SLOTS(GAP), .SAMPLE_AT_END(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_div(bit_div), .scan_en(scan_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_data(req_data), .req_par_inv(req_par_inv),
      .line_strobe(line_strobe), .line_data(line_data), .line_drive(line_drive),
      .line_rx(line_rx), .done_valid(done_valid), .done_write(done_write),
      .done_addr(done_addr), .done_status(done_status), .done_perr(done_perr),
      .done_noresp(done_noresp), .node_status(node_status), .node_perr(node_perr),
      .node_noresp(node_noresp));

   int n_chk = 0, n_fail = 0;
   int cyc = 0;

   // Node model settings per address
   bit       nd_present [0:31];
   bit [1:0] nd_in      [0:31];
   bit       nd_bad     [0:31];

   // Frame log written by the node model
   int       log_n = 0;
   bit [4:0] log_addr [0:127];
   bit       log_ap   [0:127];
   bit       log_cmd  [0:127];
   bit [1:0] log_d    [0:127];
   bit       log_dp   [0:127];
   bit       log_drv  [0:127];

   int       ns = 0;
   bit [4:0] fa;
   bit       fap, fcmd, fdp, fdrv;
   bit [1:0] fd;
   bit [3:0] resp;

   // Strobe spacing monitor
   bit mon_en = 1'b0;
   bit mon_have = 1'b0;
   int mon_last = 0, mon_short = 0, mon_gap = 0, mon_bad = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n && line_strobe) begin
         if (mon_en) begin
            if (mon_have) begin
               if (cyc - mon_last == int'(bit_div) + 1) mon_short++;
               else if (cyc - mon_last == (int'(bit_div) + 1) * (GAP + 1) + 1) mon_gap++;
               else mon_bad++;
            end
            mon_have = 1'b1;
            mon_last = cyc;
         end
         if (ns == 0) begin line_rx = 1'b0; fdrv = 1'b1; end
         if (ns < 5) begin
            fa = {fa[3:0], line_data};
            if (!line_drive) fdrv = 1'b0;
         end else if (ns == 5) begin
            fap = line_data;
            if (!line_drive) fdrv = 1'b0;
         end else if (ns == 6) begin
            fcmd = line_data;
            if (!line_drive) fdrv = 1'b0;
            resp = nd_present[fa] ? {1'b1, nd_in[fa][0], nd_in[fa][1],
                                     nd_in[fa][0] ^ nd_in[fa][1] ^ nd_bad[fa]} : 4'b0000;
         end else if (fcmd) begin
            if (line_drive) fdrv = 1'b0;
            line_rx = resp[3 - (ns - 7)];
         end else begin
            if (!line_drive) fdrv = 1'b0;
            if (ns == 7) fd[0] = line_data;
            else if (ns == 8) fd[1] = line_data;
            else fdp = line_data;
         end
         ns++;
         if ((fcmd && ns == 11) || (!fcmd && ns == 10)) begin
            if (log_n < 128) begin
               log_addr[log_n] = fa; log_ap[log_n] = fap; log_cmd[log_n] = fcmd;
               log_d[log_n] = fd; log_dp[log_n] = fdp; log_drv[log_n] = fdrv;
            end
            log_n++;
            ns = 0;
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(negedge clk) begin
      if (cyc == 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic send_req(input bit w, input int a, input bit [1:0] d, input bit inv);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_data = d; req_par_inv = inv;
      @(negedge clk);
      req_valid = 1'b0; req_par_inv = 1'b0;
   endtask

   task automatic wait_done();
      int t = 0;
      do begin @(negedge clk); t++; end while (!done_valid && t < 3000);
   endtask

   task automatic chk_frame(input int i, input int a, input bit cmd, input string tag);
      chk(int'(log_addr[i]) == a, {tag, " address"}, int'(log_addr[i]), a);
      chk(log_ap[i] == ^a[4:0], {tag, " address parity"}, int'(log_ap[i]), int'(^a[4:0]));
      chk(log_cmd[i] == cmd, {tag, " command"}, int'(log_cmd[i]), int'(cmd));
      chk(log_drv[i] == 1'b1, {tag, " drive pattern"}, int'(log_drv[i]), 1);
   endtask

   task automatic t_reset();
      chk(line_drive == 1'b1, "R1 line_drive", int'(line_drive), 1);
      chk(line_strobe == 1'b0 && line_data == 1'b0, "R1 strobe/data", int'({line_strobe, line_data}), 0);
      chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
      chk(node_status == '0 && node_perr == '0 && node_noresp == '0, "R1 arrays", 1, 0);
   endtask

   task automatic t_write();
      int b = log_n;
      send_req(1'b1, 5, 2'b10, 1'b0);
      wait_done();
      chk(done_write == 1'b1 && int'(done_addr) == 5, "R10 write done", int'({done_write, done_addr}), 32 + 5);
      chk(done_perr == 1'b0 && done_noresp == 1'b0 && done_status == 2'b00, "R10 write flags", int'({done_status, done_perr, done_noresp}), 0);
      chk(log_n == b + 1, "R3 write frame count", log_n, b + 1);
      chk_frame(b, 5, 1'b0, "R2 write");
      chk(log_d[b] == 2'b10, "R3 data bits", int'(log_d[b]), 2);
      chk(log_dp[b] == 1'b1, "R3 data parity", int'(log_dp[b]), 1);
   endtask

   task automatic t_read_ok();
      int b = log_n;
      nd_in[19] = 2'b01;
      send_req(1'b0, 19, 2'b00, 1'b0);
      wait_done();
      chk_frame(b, 19, 1'b1, "R4 read");
      chk(done_write == 1'b0 && int'(done_addr) == 19 && done_status == 2'b01, "R10 read done",
          int'({done_addr, done_status}), 19 * 4 + 1);
      @(negedge clk);
      chk(node_status[38 +: 2] == 2'b01, "R4 stored status", int'(node_status[38 +: 2]), 1);
      chk(node_perr[19] == 1'b0 && node_noresp[19] == 1'b0, "R4 clean flags",
          int'({node_perr[19], node_noresp[19]}), 0);
   endtask

   task automatic t_read_perr();
      nd_bad[7] = 1'b1;
      send_req(1'b0, 7, 2'b00, 1'b0);
      wait_done();
      chk(done_perr == 1'b1 && done_noresp == 1'b0, "R4 done_perr", int'({done_perr, done_noresp}), 2);
      @(negedge clk);
      chk(node_perr[7] == 1'b1, "R4 perr set", int'(node_perr[7]), 1);
      chk(node_status[14 +: 2] == nd_in[7], "R4 status with bad parity", int'(node_status[14 +: 2]), int'(nd_in[7]));
      nd_bad[7] = 1'b0;
      send_req(1'b0, 7, 2'b00, 1'b0);
      wait_done();
      @(negedge clk);
      chk(node_perr[7] == 1'b0, "R4 perr cleared", int'(node_perr[7]), 0);
   endtask

   task automatic t_noresp();
      nd_in[12] = 2'b10;
      send_req(1'b0, 12, 2'b00, 1'b0);
      wait_done();
      nd_present[12] = 1'b0;
      nd_in[12] = 2'b01;
      send_req(1'b0, 12, 2'b00, 1'b0);
      wait_done();
      chk(done_noresp == 1'b1 && done_perr == 1'b0, "R5 done_noresp", int'({done_noresp, done_perr}), 2);
      @(negedge clk);
      chk(node_noresp[12] == 1'b1, "R5 noresp set", int'(node_noresp[12]), 1);
      chk(node_status[24 +: 2] == 2'b10, "R5 status kept", int'(node_status[24 +: 2]), 2);
      nd_present[12] = 1'b1;
      send_req(1'b0, 12, 2'b00, 1'b0);
      wait_done();
      @(negedge clk);
      chk(node_noresp[12] == 1'b0 && node_status[24 +: 2] == 2'b01, "R5 noresp cleared",
          int'({node_noresp[12], node_status[24 +: 2]}), 1);
   endtask

   task automatic t_fault_clear();
      int b = log_n;
      send_req(1'b1, 9, 2'b11, 1'b1);
      wait_done();
      chk(log_dp[b] == 1'b1, "R3 inverted data parity", int'(log_dp[b]), 1);
      send_req(1'b1, 9, 2'b01, 1'b0);
      wait_done();
      wait_done();
      chk(log_n == b + 3, "R9 frame count with inserted read", log_n, b + 3);
      chk_frame(b + 1, 9, 1'b1, "R9 inserted read");
      chk_frame(b + 2, 9, 1'b0, "R9 write after read");
      chk(log_d[b + 2] == 2'b01 && log_dp[b + 2] == 1'b1, "R9 write data", int'({log_d[b + 2], log_dp[b + 2]}), 3);
      send_req(1'b1, 9, 2'b00, 1'b0);
      wait_done();
      chk(log_n == b + 4 && log_cmd[b + 3] == 1'b0, "R9 mark cleared, no extra read", log_n, b + 4);
   endtask

   task automatic t_div0();
      int b = log_n;
      bit_div = '0;
      @(negedge clk);
      mon_have = 1'b0; mon_short = 0; mon_gap = 0; mon_bad = 0; mon_en = 1'b1;
      nd_in[4] = 2'b10;
      send_req(1'b0, 4, 2'b00, 1'b0);
      wait_done();
      mon_en = 1'b0;
      chk(mon_short == 10 && mon_bad == 0, "R6 one-cycle slots", mon_short * 100 + mon_bad, 1000);
      chk_frame(b, 4, 1'b1, "R6 div0 frame");
      @(negedge clk);
      chk(node_status[8 +: 2] == 2'b10, "R6 div0 status", int'(node_status[8 +: 2]), 2);
      bit_div = 4'd2;
      @(negedge clk);
   endtask

   task automatic t_scan();
      int b = log_n;
      int acc_n, expa, wcnt, wpos, reads;
      mon_have = 1'b0; mon_short = 0; mon_gap = 0; mon_bad = 0; mon_en = 1'b1;
      scan_en = 1'b1;
      while (log_n < b + 10) @(negedge clk);
      acc_n = log_n;
      send_req(1'b1, 3, 2'b01, 1'b0);
      while (log_n < b + 32) @(negedge clk);
      scan_en = 1'b0;
      mon_en = 1'b0;
      repeat (100) @(negedge clk);
      expa = 0; wcnt = 0; wpos = 0; reads = 0;
      for (int i = b; i < b + 32; i++) begin
         if (log_cmd[i] == 1'b0) begin
            wcnt++; wpos = i;
            chk(int'(log_addr[i]) == 3, "R8 queued write address", int'(log_addr[i]), 3);
         end else begin
            reads++;
            chk(int'(log_addr[i]) == expa, "R7 scan order", int'(log_addr[i]), expa);
            expa = (expa == N - 1) ? 0 : expa + 1;
         end
      end
      chk(wcnt == 1, "R8 one queued write", wcnt, 1);
      chk(wpos <= acc_n + 1, "R8 write launched at next boundary", wpos, acc_n + 1);
      chk(reads == 31, "R7 wrap past 29", reads, 31);
      chk(mon_bad == 0 && mon_gap >= 30, "R6 strobe spacing", mon_bad, 0);
      chk(node_status[58 +: 2] == nd_in[29], "R7 status of address 29", int'(node_status[58 +: 2]), int'(nd_in[29]));
   endtask

   initial begin
      for (int i = 0; i < 32; i++) begin
         nd_present[i] = 1'b1; nd_in[i] = 2'(i); nd_bad[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_read_ok();
      t_read_perr();
      t_noresp();
      t_fault_clear();
      t_div0();
      t_scan();
      summary();
      $finish;
   end
endmodule